// File: doc/BRIEF.md
# Stripe-Ordered Matrix-Vector Multiplier

This block forms the product of a square N×N matrix with an N-element vector. The vector is written once into a local buffer through its own load stream. The matrix then arrives as a stream cut into horizontal bands of S rows. Inside a band, the words come column by column. Each input word carries P elements of the current column, and the P lanes add their products to P different rows. So the running sum of a row is read and written back only once every S/P accepted words. No adder result is ever needed in the next cycle, and the stream never has to stall.

The block keeps one running sum for each row of the current band. It re-reads the stored vector for every band, so the vector crosses the block's edge once however many bands follow. When the last column of a band has been absorbed, the S finished sums move to a drain buffer and the running sums return to zero. The drain then sends the results out one per cycle, in row order, each tagged with its global row number. Meanwhile the next band is already streaming in.

Top module: `stripe_matvec`

## Requirements
- R1: While `rst` is high, and after it until the first band has been absorbed, `res_valid` stays 0.
- R2: The result for row i equals the sum over j of A[i][j]·x[j]. The values are unsigned, and the result width of 2·DW+ceil(log2 N) bits never wraps, even when every element and vector entry is at its maximum.
- R3: Each band yields exactly S results on S consecutive cycles. `res_idx` counts up from band·S. Bands come out in order 0 to N/S−1, and the numbering then starts again at 0.
- R4: The first result of a band is presented by the third rising edge after the edge that accepts the band's final matrix word.
- R5: A cycle with `mat_valid` low changes no state, whatever `mat_data` holds, and a cycle with `vec_valid` low does not write the vector. Results do not depend on the gaps between accepted words.
- R6: The running sums restart at zero for every band and every new matrix, so each result depends only on its own row.
- R7: Accepted `vec_data` words fill vector positions 0 to N−1 in order, and the write position then wraps to 0, so the next N words replace the vector. A loaded vector serves every band and every later matrix until it is replaced.
- R8: The matrix words come band by band. Within a band they come column 0 to N−1, and within a column they come row group g from 0 to S/P−1. Lane k, at bits [k·DW +: DW], holds row band·S+g·P+k. The parameters must satisfy S dividing N and P dividing S.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vec_valid | input | 1 | A vector element is present |
| vec_data | input | DW | Vector element, unsigned |
| mat_valid | input | 1 | A matrix word is present |
| mat_data | input | P·DW | P column elements, lane k at bits k·DW |
| res_valid | output | 1 | A result is present |
| res_data | output | ACCW | Row dot product, unsigned |
| res_idx | output | IW | Global row number of the result |

## Verification
Some properties are checked on every cycle by the assertions. Idle cycles must leave the band, column and group counters unchanged. The column counter must advance after a group wraps, and the vector write pointer must wrap after N writes. A row's running sum must read zero right after the last column. The drain must never start a band while an earlier band is still going out, and results must come out three edges after the last word with consecutive row numbers. Other behaviour only the bench scenarios can show. These are the actual dot-product values under random, all-maximum and zero data, independence from gaps in the input, and replacing the vector between matrices. The bench also measures the exact latency from the accepting edge of each band's last word.

// File: rtl/smv_pkg.sv
package smv_pkg;
  // width of an index that counts 0..n-1, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/smv_vbuf.sv
module smv_vbuf #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int CW = smv_pkg::idx_w(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [N];
  logic [CW-1:0] wptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        wptr <= '0;
    else if (wr_en) wptr <= (wptr == CW'(N-1)) ? '0 : wptr + 1'b1;
  end

  assign rd_data = mem[rd_addr];

  // R7: the write position wraps after the last element
  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    wr_en && wptr == CW'(N-1) |=> wptr == '0);
endmodule

// File: rtl/smv_seq.sv
module smv_seq #(
  parameter int N  = 8,
  parameter int S  = 4,
  parameter int P  = 2,
  parameter int DW = 8,
  parameter int GW = smv_pkg::idx_w(S/P),
  parameter int CW = smv_pkg::idx_w(N),
  parameter int TW = smv_pkg::idx_w(N/S)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [P*DW-1:0] in_data,
  output logic            q_vld,
  output logic [P*DW-1:0] q_data,
  output logic [GW-1:0]   q_grp,
  output logic [CW-1:0]   q_col,
  output logic [TW-1:0]   q_stripe,
  output logic            q_last_col
);
  localparam int G    = S / P;
  localparam int NSTR = N / S;

  logic [GW-1:0] cnt_grp;
  logic [CW-1:0] cnt_col;
  logic [TW-1:0] cnt_str;
  logic end_grp, end_col, end_str;

  assign end_grp = (cnt_grp == GW'(G-1));
  assign end_col = (cnt_col == CW'(N-1));
  assign end_str = (cnt_str == TW'(NSTR-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_grp    <= '0;
      cnt_col    <= '0;
      cnt_str    <= '0;
      q_vld      <= 1'b0;
      q_data     <= '0;
      q_grp      <= '0;
      q_col      <= '0;
      q_stripe   <= '0;
      q_last_col <= 1'b0;
    end else begin
      q_vld <= in_vld;
      if (in_vld) begin
        q_data     <= in_data;
        q_grp      <= cnt_grp;
        q_col      <= cnt_col;
        q_stripe   <= cnt_str;
        q_last_col <= end_col;
        cnt_grp    <= end_grp ? '0 : cnt_grp + 1'b1;
        if (end_grp) begin
          cnt_col <= end_col ? '0 : cnt_col + 1'b1;
          if (end_col) cnt_str <= end_str ? '0 : cnt_str + 1'b1;
        end
      end
    end
  end

  // R5: idle cycles leave the stream position untouched
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(cnt_grp) && $stable(cnt_col) && $stable(cnt_str));

  // R8: the column advances once its last row group has been taken
  a_r8_col_step: assert property (@(posedge clk) disable iff (rst)
    in_vld && end_grp && !end_col |=> cnt_col == $past(cnt_col) + 1'b1);
endmodule

// File: rtl/smv_lanes.sv
module smv_lanes #(
  parameter int S    = 4,
  parameter int P    = 2,
  parameter int DW   = 8,
  parameter int ACCW = 19,
  parameter int GW   = smv_pkg::idx_w(S/P)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic [GW-1:0]     grp,
  input  logic              last_col,
  input  logic [P*DW-1:0]   data,
  input  logic [DW-1:0]     vec,
  output logic              fin_we,
  output logic [P*ACCW-1:0] fin_sums
);
  localparam int G = S / P;

  logic [P*ACCW-1:0] acc_mem [G];
  logic [P*ACCW-1:0] cur, nxt;

  assign cur = acc_mem[grp];

  for (genvar k = 0; k < P; k++) begin : g_lane
    assign nxt[k*ACCW +: ACCW] = cur[k*ACCW +: ACCW]
                               + ACCW'(data[k*DW +: DW]) * ACCW'(vec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < G; i++) acc_mem[i] <= '0;
    end else if (vld) begin
      acc_mem[grp] <= last_col ? '0 : nxt;
    end
  end

  assign fin_we   = vld && last_col;
  assign fin_sums = nxt;

  // R6: a row group's running sums are zero right after its last column
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    vld && last_col |=> acc_mem[$past(grp)] == '0);
endmodule

// File: rtl/smv_drain.sv
module smv_drain #(
  parameter int N    = 8,
  parameter int S    = 4,
  parameter int P    = 2,
  parameter int ACCW = 19,
  parameter int GW   = smv_pkg::idx_w(S/P),
  parameter int TW   = smv_pkg::idx_w(N/S),
  parameter int IW   = smv_pkg::idx_w(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin_we,
  input  logic [GW-1:0]     fin_grp,
  input  logic [P*ACCW-1:0] fin_sums,
  input  logic [TW-1:0]     stripe,
  output logic              res_valid,
  output logic [ACCW-1:0]   res_data,
  output logic [IW-1:0]     res_idx
);
  localparam int G  = S / P;
  localparam int PW = smv_pkg::idx_w(P);

  logic [P*ACCW-1:0] obuf [G];
  logic              busy;
  logic [GW-1:0]     egrp;
  logic [PW-1:0]     elane;
  logic [IW-1:0]     base;
  logic              fin_last, emit_last;

  assign fin_last  = fin_we && (fin_grp == GW'(G-1));
  assign emit_last = (egrp == GW'(G-1)) && (elane == PW'(P-1));

  always_ff @(posedge clk) begin
    if (fin_we) obuf[fin_grp] <= fin_sums;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      egrp      <= '0;
      elane     <= '0;
      base      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_idx   <= '0;
    end else begin
      res_valid <= busy;
      if (busy) begin
        res_data <= obuf[egrp][elane*ACCW +: ACCW];
        res_idx  <= base + IW'(egrp) * IW'(P) + IW'(elane);
        if (elane == PW'(P-1)) begin
          elane <= '0;
          egrp  <= egrp + 1'b1;
        end else begin
          elane <= elane + 1'b1;
        end
        if (emit_last) busy <= 1'b0;
      end
      if (fin_last) begin
        busy  <= 1'b1;
        egrp  <= '0;
        elane <= '0;
        base  <= IW'(int'(stripe) * S);
      end
    end
  end

  // R3: a new band never starts while an earlier one is still draining
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    fin_last |-> !busy || emit_last);

  // R3: consecutive results carry consecutive row numbers (wrap to 0)
  a_r3_order: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(res_valid) |->
      (res_idx == $past(res_idx) + 1'b1) || (res_idx == '0));

  // R4: the first result follows the last column by two edges
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    fin_last |=> ##1 res_valid);
endmodule

// File: rtl/stripe_matvec.sv
module stripe_matvec #(
  parameter int N    = 8,
  parameter int S    = 4,
  parameter int P    = 2,
  parameter int DW   = 8,
  parameter int IW   = smv_pkg::idx_w(N),
  parameter int ACCW = 2*DW + smv_pkg::idx_w(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vec_valid,
  input  logic [DW-1:0]   vec_data,
  input  logic            mat_valid,
  input  logic [P*DW-1:0] mat_data,
  output logic            res_valid,
  output logic [ACCW-1:0] res_data,
  output logic [IW-1:0]   res_idx
);
  localparam int GW = smv_pkg::idx_w(S/P);
  localparam int CW = smv_pkg::idx_w(N);
  localparam int TW = smv_pkg::idx_w(N/S);

  if ((N % S) != 0 || (S % P) != 0) begin : g_bad_geometry
    $error("stripe_matvec: S must divide N and P must divide S");
  end

  logic            q_vld, q_last_col;
  logic [P*DW-1:0] q_data;
  logic [GW-1:0]   q_grp;
  logic [CW-1:0]   q_col;
  logic [TW-1:0]   q_stripe;
  logic [DW-1:0]   vec_elem;
  logic            fin_we;
  logic [P*ACCW-1:0] fin_sums;

  smv_vbuf #(.N(N), .DW(DW), .CW(CW)) u_vbuf (
    .clk(clk), .rst(rst), .wr_en(vec_valid), .wr_data(vec_data),
    .rd_addr(q_col), .rd_data(vec_elem));

  smv_seq #(.N(N), .S(S), .P(P), .DW(DW), .GW(GW), .CW(CW), .TW(TW)) u_seq (
    .clk(clk), .rst(rst), .in_vld(mat_valid), .in_data(mat_data),
    .q_vld(q_vld), .q_data(q_data), .q_grp(q_grp), .q_col(q_col),
    .q_stripe(q_stripe), .q_last_col(q_last_col));

  smv_lanes #(.S(S), .P(P), .DW(DW), .ACCW(ACCW), .GW(GW)) u_lanes (
    .clk(clk), .rst(rst), .vld(q_vld), .grp(q_grp), .last_col(q_last_col),
    .data(q_data), .vec(vec_elem), .fin_we(fin_we), .fin_sums(fin_sums));

  smv_drain #(.N(N), .S(S), .P(P), .ACCW(ACCW), .GW(GW), .TW(TW), .IW(IW)) u_drain (
    .clk(clk), .rst(rst), .fin_we(fin_we), .fin_grp(q_grp), .fin_sums(fin_sums),
    .stripe(q_stripe), .res_valid(res_valid), .res_data(res_data),
    .res_idx(res_idx));
endmodule

// File: tb/sim_stripe_matvec.sv
`timescale 1ns/1ps
module sim_stripe_matvec;
  localparam int N    = 8;
  localparam int S    = 4;
  localparam int P    = 2;
  localparam int DW   = 8;
  localparam int G    = S / P;
  localparam int IW   = 3;
  localparam int ACCW = 2*DW + 3;

  logic            clk = 1'b0;
  logic            rst;
  logic            vec_valid;
  logic [DW-1:0]   vec_data;
  logic            mat_valid;
  logic [P*DW-1:0] mat_data;
  logic            res_valid;
  logic [ACCW-1:0] res_data;
  logic [IW-1:0]   res_idx;

  always #4 clk = ~clk;

  stripe_matvec #(.N(N), .S(S), .P(P), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .vec_valid(vec_valid), .vec_data(vec_data),
    .mat_valid(mat_valid), .mat_data(mat_data), .res_valid(res_valid),
    .res_data(res_data), .res_idx(res_idx));

  typedef struct {
    longint val;
    int     idx;
    string  tag;
  } exp_t;

  exp_t          exp_q[$];
  int            tq[$];
  int            cyc = 0;
  int            n_chk = 0;
  int            n_bad = 0;
  logic [DW-1:0] mat [N][N];
  logic [DW-1:0] vec [N];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // monitor: pop the scoreboard as results appear
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected result", longint'(res_idx), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(res_data == e.val, e.tag, longint'(res_data), e.val);
        check(int'(res_idx) == e.idx, "R3 row index", longint'(res_idx), e.idx);
        if (e.idx % S == 0) begin
          int t;
          t = (tq.size() != 0) ? tq.pop_front() : -1;
          check(cyc == t, "R4 first-result cycle", cyc, t);
        end
      end
    end
  end

  task automatic idle_cycle();
    vec_valid = 1'b0;
    vec_data  = DW'($urandom);
    mat_valid = 1'b0;
    mat_data  = (P*DW)'({$urandom, $urandom});
    @(posedge clk); #1;
  endtask

  // R7: vector words are written in order, gaps carry garbage
  task automatic load_vec(input int stall);
    for (int j = 0; j < N; j++) begin
      while ($urandom_range(0, 99) < stall) idle_cycle();
      vec_valid = 1'b1;
      vec_data  = vec[j];
      @(posedge clk); #1;
    end
    vec_valid = 1'b0;
  endtask

  // R8: driver in band / column / row-group order
  task automatic run_mat(input int stall, input string tag);
    for (int i = 0; i < N; i++) begin
      exp_t e;
      longint s;
      s = 0;
      for (int j = 0; j < N; j++) s += longint'(mat[i][j]) * longint'(vec[j]);
      e.val = s;
      e.idx = i;
      e.tag = tag;
      exp_q.push_back(e);
    end
    for (int t = 0; t < N/S; t++) begin
      for (int j = 0; j < N; j++) begin
        for (int g = 0; g < G; g++) begin
          while ($urandom_range(0, 99) < stall) idle_cycle();
          mat_valid = 1'b1;
          for (int k = 0; k < P; k++) mat_data[k*DW +: DW] = mat[t*S + g*P + k][j];
          if (j == N-1 && g == G-1) tq.push_back(cyc + 3);
          @(posedge clk); #1;
        end
      end
    end
    mat_valid = 1'b0;
    while (exp_q.size() != 0) @(posedge clk);
    #1;
    repeat (4) idle_cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    rst       = 1'b1;
    vec_valid = 1'b0;
    vec_data  = '0;
    mat_valid = 1'b0;
    mat_data  = '0;
    repeat (4) @(posedge clk);
    #1;
    check(res_valid == 1'b0, "R1 valid low in reset", res_valid, 0);
    rst = 1'b0;
    for (int c = 0; c < 5; c++) begin
      idle_cycle();
      check(res_valid == 1'b0, "R1 valid low after reset", res_valid, 0);
    end

    // random data, back-to-back words
    for (int j = 0; j < N; j++) vec[j] = DW'($urandom);
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mat[i][j] = DW'($urandom);
    load_vec(0);
    run_mat(0, "R2/R8 random values");

    // same vector, new matrix, random gaps with garbage on the data lines
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mat[i][j] = DW'($urandom);
    run_mat(40, "R5 values under stalls");

    // all maximum: widest sum, vector replaced with gaps
    for (int j = 0; j < N; j++) vec[j] = '1;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mat[i][j] = '1;
    load_vec(30);
    run_mat(20, "R2/R7 maximum values");

    // zero matrix right after the maximum one: nothing carried over
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mat[i][j] = '0;
    run_mat(0, "R6 cleared sums");

    // one-hot vector selects column 3
    for (int j = 0; j < N; j++) vec[j] = (j == 3) ? DW'(1) : DW'(0);
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mat[i][j] = DW'($urandom);
    load_vec(0);
    run_mat(10, "R7 reloaded vector");

    check(tq.size() == 0, "R4 all bands emitted", tq.size(), 0);
    summary();
    $finish;
  end
endmodule